// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a programmed-I/O SPI master for a small 32-bit register bus. Software first places one byte in the data word and then writes the control word with the go bit set. The engine shifts that byte out on the serial output while it collects one byte from the serial input. While the engine runs, the control word reads back with its busy bit high. When busy drops, a read of the data word returns the byte that came in.

The same control word also holds three chip-select levels, which drive the output pins directly. It further holds a 5-bit clock divisor and a loopback enable. The serial clock is derived from the block clock. Its half period lasts divisor+1 block cycles, so the SCK frequency is the block clock divided by 2·(divisor+1). Transfers run most significant bit first in SPI mode 0. In loopback the engine takes its own serial output as its input.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the control word reads 0x0000_0015: the three chip-select bits are 1, busy is 0, loopback is 0 and the divisor is 0. `spi_cs` is 3'b111 and `spi_sck` is low.
- R2: The control word is at byte address 0x0 and the data word is at 0x4 (`bus_addr[2]` selects between them). The control word reads chip select n at bit 2n, busy at bit 1, loopback at bit 3 and the divisor at bits 31:27. All its other bits read 0. The data word reads the received byte in bits 7:0 and zeros above.
- R3: `spi_cs[n]` takes the value of control bit 2n on the cycle after any control write. This holds during a transfer as well. No other access changes it.
- R4: A control write with bit 1 set while idle starts one transfer. Busy is high for exactly 16·(N+1) block cycles, where N is the divisor.
- R5: SCK is low whenever the block is idle. During a transfer it makes 8 pulses, and each high phase and each low phase lasts N+1 block cycles.
- R6: The byte goes out MSB first. MOSI presents bit 7 from the start and changes only on falling SCK edges. MISO is sampled on rising SCK edges. Once busy has cleared, the data word reads the 8 bits that were sampled, with the first sample in bit 7.
- R7: With control bit 3 set, the received byte equals the transmitted byte whatever the `spi_miso` pin does.
- R8: A control write with bit 1 clear updates the stored fields and starts no transfer. Busy stays 0 and SCK stays low.
- R9: While busy, a start command is ignored and writes to the data word are ignored. A control write updates only the chip selects; the divisor and loopback keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference clock for SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address; bit 2 selects the data word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select levels, straight from the control word |

## Verification
The assertions assume the following about the bus:
- A write lasts one cycle.
- Only bit 2 of the address carries meaning.
- `spi_miso` changes only on falling SCK edges, as a mode-0 slave drives it.

The bench's slave model reloads its pattern only while SCK is idle and shifts its output on SCK falling edges, so MISO is always stable at the rising-edge samples. Bus writes are issued on the falling block-clock edge and last one cycle. Random bytes and divisors are drawn from a fixed seed, with the divisor kept small so that every transfer finishes quickly.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    // Positions fixed by the software contract of the control word
    localparam int CTRL_W    = 32;
    localparam int GO_POS    = 1;   // write: go, read: busy
    localparam int LOOP_POS  = 3;
    localparam int CS_STRIDE = 2;   // chip select n at bit CS_STRIDE*n

    typedef enum logic {
        WORD_CTRL = 1'b0,
        WORD_DATA = 1'b1
    } word_sel_e;
endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
    import spi_byte_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5,
    parameter int NUM_CS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         word_sel,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start,
    output logic [NUM_CS-1:0] cs,
    output logic              loop_en,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] tx_byte,
    output logic [CTRL_W-1:0] rdata
);
    localparam int DIV_LSB = CTRL_W - DIV_W;

    typedef struct packed {
        logic [NUM_CS-1:0] cs;
        logic              loop_en;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] tx;
    } regs_t;

    regs_t s_d, s_q;
    logic  ctrl_wr, data_wr;
    logic [CTRL_W-1:0] ctrl_rd;

    always_comb begin
        ctrl_wr = wr_en && (word_sel == WORD_CTRL);
        data_wr = wr_en && (word_sel == WORD_DATA);
        s_d     = s_q;
        if (ctrl_wr) begin
            for (int i = 0; i < NUM_CS; i++) begin
                s_d.cs[i] = wdata[CS_STRIDE*i];
            end
            if (!busy) begin
                s_d.loop_en = wdata[LOOP_POS];
                s_d.div     = wdata[DIV_LSB +: DIV_W];
            end
        end
        if (data_wr && !busy) begin
            s_d.tx = wdata[DATA_W-1:0];
        end
        start = ctrl_wr && wdata[GO_POS] && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cs      <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            ctrl_rd[CS_STRIDE*i] = s_q.cs[i];
        end
        ctrl_rd[GO_POS]                = busy;
        ctrl_rd[LOOP_POS]              = s_q.loop_en;
        ctrl_rd[DIV_LSB +: DIV_W]      = s_q.div;
        rdata = (word_sel == WORD_DATA) ? CTRL_W'(rx_byte) : ctrl_rd;
    end

    assign cs      = s_q.cs;
    assign loop_en = s_q.loop_en;
    assign div     = s_q.div;
    assign tx_byte = s_q.tx;
endmodule

// File: rtl/spi_byte_clkdiv.sv
module spi_byte_clkdiv #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso_in,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [EDGE_W-1:0] edges;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rx;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (start) begin
            e_d.busy  = 1'b1;
            e_d.sck   = 1'b0;
            e_d.edges = '0;
            e_d.sh    = tx_byte;
        end else if (e_q.busy && tick) begin
            e_d.sck   = ~e_q.sck;
            e_d.edges = e_q.edges + 1'b1;
            if (!e_q.sck) begin
                // rising edge: sample
                e_d.rx = {e_q.rx[DATA_W-2:0], miso_in};
            end else begin
                // falling edge: advance output
                e_d.sh = {e_q.sh[DATA_W-2:0], 1'b0};
                if (e_q.edges == LAST_EDGE) begin
                    e_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy    = e_q.busy;
    assign sck     = e_q.sck;
    assign mosi    = e_q.sh[DATA_W-1];
    assign rx_byte = e_q.rx;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5,
    parameter int NUM_CS = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    word_sel_e         sel;
    logic              start, busy, tick, loop_en, miso_int;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_byte, rx_byte;

    assign sel      = word_sel_e'(bus_addr[2]);
    assign miso_int = loop_en ? spi_mosi : spi_miso;

    spi_byte_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .word_sel(sel),
        .wdata(bus_wdata), .busy(busy), .rx_byte(rx_byte), .start(start),
        .cs(spi_cs), .loop_en(loop_en), .div(div), .tx_byte(tx_byte),
        .rdata(bus_rdata)
    );

    spi_byte_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
    );

    spi_byte_shifter #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
        .tick(tick), .miso_in(miso_int), .busy(busy), .sck(spi_sck),
        .mosi(spi_mosi), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 5,
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              data_wr,
    input logic              go_bit,
    input logic              busy,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs,
    input logic [DIV_W-1:0]  div,
    input logic              loop_en,
    input logic [DATA_W-1:0] tx_byte
);
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cs));

    p_go_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && go_bit && !busy) |=> busy);

    p_nogo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !go_bit && !busy) |=> !busy);

    p_div_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> ($stable(div) && $stable(loop_en)));

    p_tx_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && data_wr) |=> $stable(tx_byte));

    p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(sck)) |-> $stable(mosi));
endmodule

bind spi_byte_master spi_byte_master_chk #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(bus_wr && !bus_addr[2]),
    .data_wr(bus_wr && bus_addr[2]),
    .go_bit(bus_wdata[1]),
    .busy(busy), .sck(spi_sck), .mosi(spi_mosi), .cs(spi_cs),
    .div(div), .loop_en(loop_en), .tx_byte(tx_byte)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [2:0]  spi_cs;

    int checks = 0;
    int errors = 0;
    int unsigned cyc = 0;
    logic [7:0] sl_out = 8'h00;
    logic [7:0] sl_cap = 8'h00;
    logic [2:0] cs_shadow = 3'b111;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // mode-0 slave: sample on rise, advance on fall
    assign spi_miso = sl_out[7];
    always @(posedge spi_sck) sl_cap <= {sl_cap[6:0], spi_mosi};
    always @(negedge spi_sck) sl_out <= {sl_out[6:0], 1'b0};

    spi_byte_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    function automatic logic [31:0] mk_ctrl(input logic [2:0] cs, input logic lp,
                                            input logic [4:0] n, input logic go);
        mk_ctrl = {n, 27'b0};
        mk_ctrl[0] = cs[0];
        mk_ctrl[1] = go;
        mk_ctrl[2] = cs[1];
        mk_ctrl[3] = lp;
        mk_ctrl[4] = cs[2];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 4'h0;
        #0;
    endtask

    task automatic wait_idle(input int unsigned t0, output int dur, output int hi);
        int guard = 0;
        hi = 0;
        while (bus_rdata[1] === 1'b1 && guard < 100000) begin
            hi += int'(spi_sck);
            @(negedge clk);
            guard++;
        end
        dur = int'(cyc - t0);
    endtask

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] pat,
                            input logic [4:0] n, input logic lp, input string tag);
        int dur, hi;
        int unsigned t0;
        logic [31:0] rd;
        bus_write(4'h4, {24'h0, tx});
        sl_out = pat;
        bus_write(4'h0, mk_ctrl(cs_shadow, lp, n, 1'b1));
        t0 = cyc;
        wait_idle(t0, dur, hi);
        check({"R4 busy length ", tag}, dur, 16 * (n + 1));
        check({"R5 sck high cycles ", tag}, hi, 8 * (n + 1));
        check({"R5 sck idle low ", tag}, {31'b0, spi_sck}, 32'h0);
        if (!lp) check({"R6 slave saw msb-first byte ", tag}, {24'h0, sl_cap}, {24'h0, tx});
        bus_read(4'h4, rd);
        if (lp) check({"R7 loopback rx ", tag}, rd, {24'h0, tx});
        else    check({"R6 received byte ", tag}, rd, {24'h0, pat});
        bus_read(4'h0, rd);
        check({"R2 ctrl readback ", tag}, rd, mk_ctrl(cs_shadow, lp, n, 1'b0));
    endtask

    initial begin
        logic [31:0] rd;
        int dur, hi;
        int unsigned t0;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, rd);
        check("R1 ctrl reset value", rd, 32'h0000_0015);
        check("R1 cs pins after reset", {29'b0, spi_cs}, 32'h7);
        check("R1 sck low after reset", {31'b0, spi_sck}, 32'h0);
        bus_read(4'h4, rd);
        check("R2 data word after reset", rd, 32'h0);

        // R3/R8 chip-select write without go
        bus_write(4'h0, mk_ctrl(3'b101, 1'b0, 5'd0, 1'b0));
        check("R3 cs pins follow bits 0,2,4", {29'b0, spi_cs}, 32'h5);
        repeat (4) @(negedge clk);
        bus_read(4'h0, rd);
        check("R8 no transfer without go", {31'b0, rd[1]}, 32'h0);
        check("R8 sck stays low", {31'b0, spi_sck}, 32'h0);
        check("R2 ctrl readback after cs write", rd, 32'h0000_0011);

        // R2 unimplemented bits read zero
        bus_write(4'h0, 32'h07FF_FFE5);
        bus_read(4'h0, rd);
        check("R2 unused bits read zero", rd, 32'h0000_0005);
        check("R3 cs pins 011", {29'b0, spi_cs}, 32'h3);
        cs_shadow = 3'b011;

        // directed divisors
        run_xfer(8'hA5, 8'h3C, 5'd0, 1'b0, "n0");
        run_xfer(8'h81, 8'h7E, 5'd1, 1'b0, "n1");
        run_xfer(8'h01, 8'h80, 5'd3, 1'b0, "n3");
        run_xfer(8'hFE, 8'h01, 5'd7, 1'b0, "n7");
        run_xfer(8'hC3, 8'h00, 5'd31, 1'b0, "n31");

        // random transfers
        for (int k = 0; k < 6; k++) begin
            logic [7:0] tx, pat;
            logic [4:0] n;
            tx = 8'($urandom);
            pat = 8'($urandom);
            n = 5'($urandom_range(0, 5));
            cs_shadow = 3'($urandom);
            run_xfer(tx, pat, n, 1'b0, "rand");
        end

        // R7 loopback ignores pin
        run_xfer(8'h96, 8'h69, 5'd2, 1'b1, "loop");
        run_xfer(8'h3B, 8'hC4, 5'd0, 1'b1, "loop0");

        // R9 writes during busy
        cs_shadow = 3'b111;
        bus_write(4'h4, 32'h0000_005A);
        sl_out = 8'hF0;
        bus_write(4'h0, mk_ctrl(cs_shadow, 1'b0, 5'd3, 1'b1));
        t0 = cyc;
        repeat (5) @(negedge clk);
        bus_write(4'h4, 32'h0000_00FF);
        bus_write(4'h0, mk_ctrl(3'b010, 1'b1, 5'd0, 1'b1));
        check("R9 cs still updates while busy", {29'b0, spi_cs}, 32'h2);
        cs_shadow = 3'b010;
        wait_idle(t0, dur, hi);
        check("R9 busy length unaffected", dur, 64);
        check("R9 transmitted byte unaffected", {24'h0, sl_cap}, 32'h5A);
        bus_read(4'h0, rd);
        check("R9 divisor and loop kept", rd, mk_ctrl(3'b010, 1'b0, 5'd3, 1'b0));
        repeat (3) @(negedge clk);
        bus_read(4'h0, rd);
        check("R9 ignored go started nothing", {31'b0, rd[1]}, 32'h0);
        // data write was dropped: resend without writing data
        sl_out = 8'h11;
        bus_write(4'h0, mk_ctrl(cs_shadow, 1'b0, 5'd0, 1'b1));
        t0 = cyc;
        wait_idle(t0, dur, hi);
        check("R9 data write during busy ignored", {24'h0, sl_cap}, 32'h5A);
        check("R4 busy length n0 rerun", dur, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule